// File: doc/BRIEF.md
# Trap Namespace Save/Restore Controller

This block keeps, for each of three privilege levels, the instruction namespace that the decoder appends as hidden opcode bits, and switches it on trap entry and trap return. Each level has an active namespace, a saved ("last") namespace and a table of handler namespaces indexed by trap cause. On entry the active value is parked in the saved register and the handler namespace is installed. On return the parked value is put back and the saved register is refilled with the handler value. A swap takes place only when the two values differ.

The pipeline raises trap-entry or trap-exit strobes together with the privilege level and cause. It waits for `pc_update_ok` before it redirects the PC, so the namespace is always updated before the PC changes. Software reaches every register through a simple CSR write/read port.

Top module: `trap_ns_switch`

## Requirements
- R1: After reset every active, saved and handler-table register of every level reads zero, and `pc_update_ok` is low.
- R2: On a trap entry at a level whose active namespace differs from the handler namespace, the next cycle shows the saved register holding the old active value and the active register holding the handler value.
- R3: On a trap entry whose active namespace already equals the handler namespace, neither the active nor the saved register changes.
- R4: On a trap exit whose saved namespace differs from the handler namespace, the next cycle shows the active register holding the old saved value and the saved register holding the handler value.
- R5: On a trap exit whose saved namespace equals the handler namespace, neither register changes.
- R6: `pc_update_ok` is high for exactly the one cycle after an accepted strobe, which is the same cycle in which the updated namespace first appears at `active_ns`. It is low in every other cycle.
- R7: The handler namespace used by both the entry and the exit comparisons is the table entry of the addressed level selected by the trap cause.
- R8: An event at one level leaves the registers of the other levels unchanged.
- R9: The CSR port uses select code 0 for the active register, 1 for the handler-table entry at `csr_idx`, 2 for the saved register and 3 for nothing (reads zero). Writes take effect in the next cycle. A write to the active or saved register of a level that has a trap event in the same cycle is discarded. Other writes in that cycle do take effect, and the event compares against the value held before the write.
- R10: When entry and exit are strobed in the same cycle, only the entry is performed.
- R11: The level code is 0 for user, 1 for supervisor and 3 for machine. Events and CSR writes carrying code 2 change nothing and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_enter_i | input | 1 | Trap-entry strobe |
| trap_exit_i | input | 1 | Trap-return strobe |
| trap_lvl_i | input | 2 | Privilege level of the event |
| trap_cause_i | input | CAUSE_W | Cause used to index the handler table |
| csr_we_i | input | 1 | CSR write enable |
| csr_lvl_i | input | 2 | Level addressed by the CSR port |
| csr_sel_i | input | 2 | Register select (see R9) |
| csr_idx_i | input | CAUSE_W | Handler-table entry for select 1 |
| csr_wdata_i | input | NS_W | CSR write data |
| csr_rdata_o | output | NS_W | Combinational read of the selected register |
| active_ns_o | output | 3*NS_W | Active namespace per level, user in the low slice |
| pc_update_ok_o | output | 1 | PC redirection permitted |

## Verification
A sweep over every level and every cause loads a distinct handler value, forces the active value away from it, and then runs entry, repeated entry, exit and repeated exit. This separates the swap paths from the hold paths and shows whether the cause index reaches both comparisons. Every check compares all three levels, so a leak between levels is caught. Directed cycles then collide CSR writes with events, strobe entry and exit together, and use the unused level code, which tells apart the priority rules and the decoding of invalid levels.

// File: rtl/nsx_pkg.sv
package nsx_pkg;

  localparam int LVL_N = 3;

  typedef enum logic [1:0] {
    SEL_ACTIVE = 2'd0,
    SEL_TRAP   = 2'd1,
    SEL_LAST   = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;

  // Level code 2 is unused; 0 user, 1 supervisor, 3 machine.
  function automatic logic lvl_valid(input logic [1:0] code);
    return code != 2'd2;
  endfunction

  function automatic logic [1:0] lvl_index(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/nsx_event_decode.sv
module nsx_event_decode
  import nsx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_i,
  input  logic             exit_i,
  input  logic [1:0]       lvl_i,
  output logic [LVL_N-1:0] ent_vec_o,
  output logic [LVL_N-1:0] ext_vec_o,
  output logic             pc_ok_o
);

  logic       ev_valid;
  logic [1:0] ev_idx;
  logic       pc_ok_d;
  logic       pc_ok_q;

  assign ev_valid = lvl_valid(lvl_i);
  assign ev_idx   = lvl_index(lvl_i);

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    assign ent_vec_o[g] = enter_i && ev_valid && (ev_idx == g[1:0]);
    assign ext_vec_o[g] = exit_i && !enter_i && ev_valid && (ev_idx == g[1:0]);
  end

  always_comb begin
    pc_ok_d = (enter_i || exit_i) && ev_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_ok_q <= 1'b0;
    else        pc_ok_q <= pc_ok_d;
  end

  assign pc_ok_o = pc_ok_q;

  // R6: permission follows every accepted strobe by one cycle
  a_r6_pulse_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((enter_i || exit_i) && lvl_i != 2'd2) |=> pc_ok_o);
  // R11: no pulse without an accepted strobe
  a_r11_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !((enter_i || exit_i) && lvl_i != 2'd2) |=> !pc_ok_o);
  // R10: at most one event reaches the banks per cycle
  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_vec_o | ext_vec_o) && ((ent_vec_o & ext_vec_o) == '0));

endmodule

// File: rtl/nsx_trap_store.sv
module nsx_trap_store #(
  parameter int NS_W     = 8,
  parameter int CAUSE_N  = 8,
  parameter bit VEC_MODE = 1'b1,
  localparam int CAUSE_W = (CAUSE_N > 1) ? $clog2(CAUSE_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [CAUSE_W-1:0] wr_idx_i,
  input  logic [NS_W-1:0]    wr_data_i,
  input  logic [CAUSE_W-1:0] ev_idx_i,
  output logic [NS_W-1:0]    ev_ns_o,
  output logic [NS_W-1:0]    rd_ns_o
);

  if (VEC_MODE) begin : g_table
    logic [NS_W-1:0] tab_q [CAUSE_N];
    logic [NS_W-1:0] tab_d [CAUSE_N];

    always_comb begin
      for (int k = 0; k < CAUSE_N; k++) begin
        tab_d[k] = tab_q[k];
        if (wr_en_i && (int'(wr_idx_i) == k)) tab_d[k] = wr_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < CAUSE_N; k++) tab_q[k] <= '0;
      end else if (wr_en_i) begin
        for (int k = 0; k < CAUSE_N; k++) tab_q[k] <= tab_d[k];
      end
    end

    assign ev_ns_o = (int'(ev_idx_i) < CAUSE_N) ? tab_q[ev_idx_i] : '0;
    assign rd_ns_o = (int'(wr_idx_i) < CAUSE_N) ? tab_q[wr_idx_i] : '0;
  end else begin : g_single
    logic [NS_W-1:0] trap_q;
    logic            unused_idx;

    assign unused_idx = ^{wr_idx_i, ev_idx_i};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       trap_q <= '0;
      else if (wr_en_i) trap_q <= wr_data_i;
    end

    assign ev_ns_o = trap_q;
    assign rd_ns_o = trap_q;
  end

endmodule

// File: rtl/nsx_level_bank.sv
module nsx_level_bank #(
  parameter int NS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  logic            exit_i,
  input  logic [NS_W-1:0] trap_ns_i,
  input  logic            we_active_i,
  input  logic            we_last_i,
  input  logic [NS_W-1:0] wdata_i,
  output logic [NS_W-1:0] active_o,
  output logic [NS_W-1:0] last_o
);

  logic [NS_W-1:0] active_q, active_d;
  logic [NS_W-1:0] last_q,   last_d;
  logic            upd_en;

  always_comb begin
    active_d = active_q;
    last_d   = last_q;
    if (enter_i) begin
      if (active_q != trap_ns_i) begin
        last_d   = active_q;
        active_d = trap_ns_i;
      end
    end else if (exit_i) begin
      if (last_q != trap_ns_i) begin
        active_d = last_q;
        last_d   = trap_ns_i;
      end
    end else begin
      if (we_active_i) active_d = wdata_i;
      if (we_last_i)   last_d   = wdata_i;
    end
  end

  assign upd_en = enter_i || exit_i || we_active_i || we_last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      last_q   <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      last_q   <= last_d;
    end
  end

  assign active_o = active_q;
  assign last_o   = last_q;

  // R2
  a_r2_entry_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && active_o != trap_ns_i) |=>
      (active_o == $past(trap_ns_i)) && (last_o == $past(active_o)));
  // R3
  a_r3_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && active_o == trap_ns_i) |=> $stable(active_o) && $stable(last_o));
  // R4
  a_r4_exit_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_i && exit_i && last_o != trap_ns_i) |=>
      (active_o == $past(last_o)) && (last_o == $past(trap_ns_i)));
  // R5
  a_r5_exit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_i && exit_i && last_o == trap_ns_i) |=> $stable(active_o) && $stable(last_o));
  // R8 / R9: idle level without writes keeps its state
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_i && !exit_i && !we_active_i && !we_last_i) |=> $stable(active_o) && $stable(last_o));

endmodule

// File: rtl/trap_ns_switch.sv
module trap_ns_switch
  import nsx_pkg::*;
#(
  parameter int NS_W     = 8,
  parameter int CAUSE_N  = 8,
  parameter bit VEC_MODE = 1'b1,
  localparam int CAUSE_W = (CAUSE_N > 1) ? $clog2(CAUSE_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trap_enter_i,
  input  logic                    trap_exit_i,
  input  logic [1:0]              trap_lvl_i,
  input  logic [CAUSE_W-1:0]      trap_cause_i,
  input  logic                    csr_we_i,
  input  logic [1:0]              csr_lvl_i,
  input  logic [1:0]              csr_sel_i,
  input  logic [CAUSE_W-1:0]      csr_idx_i,
  input  logic [NS_W-1:0]         csr_wdata_i,
  output logic [NS_W-1:0]         csr_rdata_o,
  output logic [LVL_N*NS_W-1:0]   active_ns_o,
  output logic                    pc_update_ok_o
);

  logic [LVL_N-1:0] ent_vec, ext_vec;
  logic [NS_W-1:0]  act_w [LVL_N];
  logic [NS_W-1:0]  lst_w [LVL_N];
  logic [NS_W-1:0]  trp_ev_w [LVL_N];
  logic [NS_W-1:0]  trp_rd_w [LVL_N];
  logic             csr_lvl_ok;
  logic [1:0]       csr_lvl_idx;
  csr_sel_e         sel;

  assign csr_lvl_ok  = lvl_valid(csr_lvl_i);
  assign csr_lvl_idx = lvl_index(csr_lvl_i);
  assign sel         = csr_sel_e'(csr_sel_i);

  nsx_event_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_i   (trap_enter_i),
    .exit_i    (trap_exit_i),
    .lvl_i     (trap_lvl_i),
    .ent_vec_o (ent_vec),
    .ext_vec_o (ext_vec),
    .pc_ok_o   (pc_update_ok_o)
  );

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    logic hit;
    assign hit = csr_we_i && csr_lvl_ok && (csr_lvl_idx == g[1:0]);

    nsx_trap_store #(
      .NS_W     (NS_W),
      .CAUSE_N  (CAUSE_N),
      .VEC_MODE (VEC_MODE)
    ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (hit && sel == SEL_TRAP),
      .wr_idx_i  (csr_idx_i),
      .wr_data_i (csr_wdata_i),
      .ev_idx_i  (trap_cause_i),
      .ev_ns_o   (trp_ev_w[g]),
      .rd_ns_o   (trp_rd_w[g])
    );

    nsx_level_bank #(
      .NS_W (NS_W)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_i     (ent_vec[g]),
      .exit_i      (ext_vec[g]),
      .trap_ns_i   (trp_ev_w[g]),
      .we_active_i (hit && sel == SEL_ACTIVE),
      .we_last_i   (hit && sel == SEL_LAST),
      .wdata_i     (csr_wdata_i),
      .active_o    (act_w[g]),
      .last_o      (lst_w[g])
    );

    assign active_ns_o[g*NS_W +: NS_W] = act_w[g];
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_lvl_ok) begin
      for (int k = 0; k < LVL_N; k++) begin
        if (csr_lvl_idx == k[1:0]) begin
          case (sel)
            SEL_ACTIVE: csr_rdata_o = act_w[k];
            SEL_TRAP:   csr_rdata_o = trp_rd_w[k];
            SEL_LAST:   csr_rdata_o = lst_w[k];
            default:    csr_rdata_o = '0;
          endcase
        end
      end
    end
  end

  // R6: the namespace has moved when the permission is raised
  a_r6_ns_before_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter_i && trap_lvl_i == 2'd0 && act_w[0] != trp_ev_w[0]) |=>
      (pc_update_ok_o && active_ns_o[NS_W-1:0] == $past(trp_ev_w[0])));
  // R11: invalid level leaves all active namespaces unchanged
  a_r11_invalid_level: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_lvl_i == 2'd2 && !(csr_we_i && csr_lvl_ok)) |=> $stable(active_ns_o));

endmodule

// File: tb/trap_ns_switch_tb_top.sv
`timescale 1ns/1ps
module trap_ns_switch_tb_top;

  localparam int NS_W = 8;
  localparam int CN   = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            t_en, t_ex, c_we;
  logic [1:0]      t_lvl, c_lvl, c_sel;
  logic [2:0]      t_cause, c_idx;
  logic [NS_W-1:0] c_wd, c_rd;
  logic [3*NS_W-1:0] act;
  logic            pc_ok;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [NS_W-1:0] m_act [3];
  logic [NS_W-1:0] m_lst [3];
  logic [NS_W-1:0] m_tab [3][CN];
  logic            m_ok;

  always #2.5 clk = ~clk;

  trap_ns_switch #(.NS_W(NS_W), .CAUSE_N(CN), .VEC_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .trap_enter_i(t_en), .trap_exit_i(t_ex), .trap_lvl_i(t_lvl), .trap_cause_i(t_cause),
    .csr_we_i(c_we), .csr_lvl_i(c_lvl), .csr_sel_i(c_sel), .csr_idx_i(c_idx),
    .csr_wdata_i(c_wd), .csr_rdata_o(c_rd), .active_ns_o(act), .pc_update_ok_o(pc_ok)
  );

  function automatic logic [1:0] code_of(int i);
    return (i == 2) ? 2'd3 : 2'(i);
  endfunction

  function automatic int idx_of(logic [1:0] c);
    return (c == 2'd3) ? 2 : int'(c);
  endfunction

  task automatic chk(bit ok, string tag, int a, int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic check_state(string tag);
    chk(pc_ok == m_ok, {tag, " R6 pulse"}, pc_ok, m_ok);
    for (int i = 0; i < 3; i++) begin
      chk(act[i*NS_W +: NS_W] == m_act[i], {tag, " active"}, act[i*NS_W +: NS_W], m_act[i]);
      c_lvl = code_of(i); c_sel = 2'd2; #0.2;
      chk(c_rd == m_lst[i], {tag, " last"}, c_rd, m_lst[i]);
    end
    c_sel = 2'd3;
  endtask

  task automatic cyc(input bit en, input bit ex, input logic [1:0] lv, input logic [2:0] ca,
                     input bit we, input logic [1:0] cl, input logic [1:0] cs,
                     input logic [2:0] ci, input logic [NS_W-1:0] wd, input string tag);
    bit ev_hit;
    int li;
    int ci_l;
    logic [NS_W-1:0] tn;
    t_en = en; t_ex = ex; t_lvl = lv; t_cause = ca;
    c_we = we; c_lvl = cl; c_sel = cs; c_idx = ci; c_wd = wd;
    ev_hit = (en || ex) && lv != 2'd2;
    li = idx_of(lv);
    m_ok = ev_hit;
    if (ev_hit) begin
      tn = m_tab[li][ca];
      if (en) begin
        if (m_act[li] != tn) begin m_lst[li] = m_act[li]; m_act[li] = tn; end
      end else begin
        if (m_lst[li] != tn) begin m_act[li] = m_lst[li]; m_lst[li] = tn; end
      end
    end
    if (we && cl != 2'd2) begin
      ci_l = idx_of(cl);
      if (cs == 2'd1) m_tab[ci_l][ci] = wd;
      else if (!(ev_hit && ci_l == li)) begin
        if (cs == 2'd0) m_act[ci_l] = wd;
        if (cs == 2'd2) m_lst[ci_l] = wd;
      end
    end
    @(posedge clk);
    @(negedge clk);
    t_en = 0; t_ex = 0; c_we = 0;
    check_state(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NS_W-1:0] tv;
    rst_n = 0; t_en = 0; t_ex = 0; t_lvl = 0; t_cause = 0;
    c_we = 0; c_lvl = 0; c_sel = 3; c_idx = 0; c_wd = 0;
    for (int i = 0; i < 3; i++) begin
      m_act[i] = 0; m_lst[i] = 0;
      for (int k = 0; k < CN; k++) m_tab[i][k] = 0;
    end
    m_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state including every table entry
    check_state("R1");
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < CN; k++) begin
        c_lvl = code_of(i); c_sel = 2'd1; c_idx = 3'(k); #0.2;
        chk(c_rd == 0, "R1 table", c_rd, 0);
      end

    // Sweep all levels and causes: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < CN; k++) begin
        tv = NS_W'((i * 37 + k * 11 + 1) & 8'hFF);
        cyc(0, 0, 0, 0, 1, code_of(i), 2'd1, 3'(k), tv, "R9 table write");
        cyc(0, 0, 0, 0, 1, code_of(i), 2'd0, 0, tv ^ 8'h5A, "R9 active write");
        cyc(1, 0, code_of(i), 3'(k), 0, 0, 3, 0, 0, "R2 R7 entry swap");
        cyc(1, 0, code_of(i), 3'(k), 0, 0, 3, 0, 0, "R3 entry hold");
        cyc(0, 1, code_of(i), 3'(k), 0, 0, 3, 0, 0, "R4 R7 exit restore");
        cyc(0, 1, code_of(i), 3'(k), 0, 0, 3, 0, 0, "R5 exit hold");
        cyc(1, 0, code_of(i), 3'((k + 1) % CN), 0, 0, 3, 0, 0, "R7 other cause entry");
      end

    // R9: collision on same level is discarded, other level takes the write
    cyc(1, 0, 2'd1, 3'd2, 1, 2'd1, 2'd0, 0, 8'hC3, "R9 same-level drop");
    cyc(0, 1, 2'd1, 3'd2, 1, 2'd1, 2'd2, 0, 8'h3C, "R9 same-level last drop");
    cyc(1, 0, 2'd0, 3'd4, 1, 2'd3, 2'd0, 0, 8'h77, "R9 R8 other-level write");
    cyc(1, 0, 2'd3, 3'd5, 1, 2'd3, 2'd1, 3'd5, 8'hE1, "R9 table write with event");
    cyc(1, 0, 2'd3, 3'd5, 0, 0, 3, 0, 0, "R7 new table value used");
    // R10: both strobes -> entry only
    cyc(0, 0, 0, 0, 1, 2'd0, 2'd1, 3'd6, 8'h99, "R9 setup");
    cyc(1, 1, 2'd0, 3'd6, 0, 0, 3, 0, 0, "R10 entry wins");
    // R11: level code 2 ignored
    cyc(1, 0, 2'd2, 3'd1, 0, 0, 3, 0, 0, "R11 invalid entry");
    cyc(0, 1, 2'd2, 3'd1, 1, 2'd2, 2'd0, 0, 8'h11, "R11 invalid exit and write");
    cyc(0, 0, 0, 0, 0, 0, 3, 0, 0, "R6 idle no pulse");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule